// File: doc/BRIEF.md
# Multichannel Double-Edge Serial Sample Serializer

This block turns one parallel word per channel per sample period into a one-bit serial lane per channel. A single design clock runs at W (12 by default) times the sample rate. Each design clock carries one bit, which models a bit clock at half that rate that moves data on both of its edges. The block drives a bit clock and a frame clock beside the lanes, so that a receiver can find word boundaries. Within each frame the bits go out least-significant first.

Words come in through a valid/ready port. `in_ready` is high for exactly one design clock per frame: the last bit slot. The word is taken on that cycle when `in_valid` is also high. A producer that is not ready simply keeps `in_valid` low. The frame then carries a zero word as a bubble, and nothing stalls. A producer whose word is not yet taken holds it until the next slot in which `in_ready` is high. A taken word goes through a fixed pipeline of LATENCY frames before it is sent.

Two options are sampled at each frame boundary. The first picks offset-binary or two's-complement output. The second replaces all lanes with an alternating alignment pattern. W must be even.

Top module: `sser_serializer`

## Requirements
- R1: `bit_clk` is high in even bit slots and low in odd bit slots, so it toggles on every design clock. Slot 0 is the first slot of a frame.
- R2: `frame_clk` is high in slots 0 to W/2-1 of every frame and low in the remaining slots.
- R3: `in_ready` is high only in slot W-1. The word on `in_data` is taken at that edge when `in_valid` is high. When `in_valid` is low there, a zero word is taken in its place.
- R4: Bit i of a channel word is driven on that channel's lane during slot i, so D0 is sent first and D(W-1) last.
- R5: A word taken at the end of frame f is sent during frame f+LATENCY (LATENCY = 12). Channel c uses `in_data[c*W +: W]` and `lane[c]`.
- R6: When `fmt_twos` is 1 at the end of frame k, frame k+1 carries the stored word with its top bit inverted (two's complement). When it is 0, the word is sent unchanged (offset binary).
- R7: When the pattern select is active for a frame, every lane sends 0x555 in odd frames and 0xAAA in even frames, whatever the value of `fmt_twos`.
- R8: `pat_en` is sampled only at the last slot of a frame and applies to the next frame. Changes of `pat_en` that are undone within a frame have no effect.
- R9: Frames are numbered from 0, and frame 0 starts on the first clock after reset is released. Before frame LATENCY, all lanes drive 0 and `out_valid` is 0. From frame LATENCY onward, `out_valid` is 1 and stays 1.
- R10: During reset, `lane` is 0, `out_valid` is 0, `in_ready` is 0, and both `bit_clk` and `frame_clk` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock, W times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word set is present on `in_data` |
| in_ready | output | 1 | High in the last slot of each frame |
| in_data | input | CH*W | One W-bit word per channel, channel 0 in the low bits |
| fmt_twos | input | 1 | 1 selects two's-complement output |
| pat_en | input | 1 | 1 selects the alignment pattern |
| lane | output | CH | Serial data, one bit per channel |
| bit_clk | output | 1 | Bit clock, toggles on every design clock |
| frame_clk | output | 1 | High during the first half of each frame |
| out_valid | output | 1 | Lanes carry pipelined data |

## Verification
`bit_clk`, `frame_clk` and `in_ready` depend only on the slot counter, so they are checked on every cycle against `t mod W`, where t counts design clocks since reset was released. A word taken at the posedge that ends frame f is loaded into the shifters at the posedge that ends frame f+LATENCY-1. Its bit i is therefore sampled at the negedge in slot i of frame f+LATENCY. The bench rebuilds each lane word over the W slots of a frame and compares it at slot W-1. The option values are recorded in the bench at the moment the frame-ending posedge samples them. That recorded value sets the expected format or pattern of the following frame. Mid-frame pulses of `pat_en` are therefore expected to change nothing.

// File: rtl/sser_pkg.sv
package sser_pkg;

  // Option values captured at a frame boundary for the following frame.
  typedef struct packed {
    logic pattern;
    logic twos;
    logic phase;
  } frame_cfg_t;

  // Alternating alignment word: phase 0 sets even bits, phase 1 sets odd bits.
  function automatic logic [63:0] alt_bits(input logic phase);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = phase ? (i % 2 == 1) : (i % 2 == 0);
    return r;
  endfunction

endpackage

// File: rtl/sser_frame_timer.sv
module sser_frame_timer #(
  parameter int W = 12,
  localparam int SLOT_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot,
  output logic              last,
  output logic              bit_clk,
  output logic              frame_clk
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(W - 1);
  localparam logic [SLOT_W-1:0] HALF_SLOT = SLOT_W'(W / 2);

  always_ff @(posedge clk) begin
    if (!rst_n)      slot <= '0;
    else if (last)   slot <= '0;
    else             slot <= slot + 1'b1;
  end

  assign last      = (slot == LAST_SLOT);
  assign bit_clk   = ~slot[0];
  assign frame_clk = (slot < HALF_SLOT);
endmodule

// File: rtl/sser_word_delay.sv
module sser_word_delay #(
  parameter int WORD   = 96,
  parameter int STAGES = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [WORD-1:0] din,
  output logic [WORD-1:0] dout
);
  logic [WORD-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)    stage_q[s] <= '0;
        else if (step) stage_q[s] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)    stage_q[s] <= '0;
        else if (step) stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sser_lane.sv
module sser_lane #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         bit_out
);
  logic [W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n)    shreg <= '0;
    else if (load) shreg <= word;
    else           shreg <= {1'b0, shreg[W-1:1]};
  end

  assign bit_out = shreg[0];
endmodule

// File: rtl/sser_serializer.sv
module sser_serializer
  import sser_pkg::*;
#(
  parameter int CH      = 8,
  parameter int W       = 12,
  parameter int LATENCY = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CH*W-1:0] in_data,
  input  logic          fmt_twos,
  input  logic          pat_en,
  output logic [CH-1:0] lane,
  output logic          bit_clk,
  output logic          frame_clk,
  output logic          out_valid
);
  localparam int WORD   = CH * W;
  localparam int STAGES = LATENCY - 1;
  localparam int SLOT_W = (W > 1) ? $clog2(W) : 1;
  localparam int CNT_W  = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LATENCY);

  logic [SLOT_W-1:0] slot;
  logic              boundary;
  logic [WORD-1:0]   entry;
  logic [WORD-1:0]   aged;
  logic              phase_q;
  logic [CNT_W-1:0]  frames_q;
  frame_cfg_t        cfg;
  logic [W-1:0]      pattern_word;
  logic [CH-1:0]     raw_lane;

  sser_frame_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .slot(slot), .last(boundary),
    .bit_clk(bit_clk), .frame_clk(frame_clk)
  );

  assign in_ready = boundary;
  assign entry    = (in_valid && boundary) ? in_data : '0;

  sser_word_delay #(.WORD(WORD), .STAGES(STAGES)) u_delay (
    .clk(clk), .rst_n(rst_n), .step(boundary), .din(entry), .dout(aged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        phase_q <= 1'b0;
    else if (boundary) phase_q <= ~phase_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               frames_q <= '0;
    else if (boundary && frames_q != CNT_FULL) frames_q <= frames_q + 1'b1;
  end

  assign out_valid = (frames_q == CNT_FULL);

  always_comb begin
    cfg.pattern = pat_en;
    cfg.twos    = fmt_twos;
    cfg.phase   = phase_q;
  end

  assign pattern_word = W'(alt_bits(cfg.phase));

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [W-1:0] stored;
    logic [W-1:0] shaped;
    assign stored = aged[c*W +: W];
    always_comb begin
      if (cfg.pattern)   shaped = pattern_word;
      else if (cfg.twos) shaped = {~stored[W-1], stored[W-2:0]};
      else               shaped = stored;
    end
    sser_lane #(.W(W)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(boundary), .word(shaped),
      .bit_out(raw_lane[c])
    );
  end

  assign lane = out_valid ? raw_lane : '0;
endmodule

// File: rtl/sser_serializer_chk.sv
module sser_serializer_chk #(
  parameter int CH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          bit_clk,
  input logic          frame_clk,
  input logic          out_valid,
  input logic [CH-1:0] lane
);
  // R1: bit clock changes level on every design clock
  a_r1_bit_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bit_clk != $past(bit_clk)));

  // R3: ready lasts one cycle and is followed by the start of a frame
  a_r3_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
  a_r3_ready_then_frame: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> $rose(frame_clk));

  // R9: quiet lanes before valid, valid never drops, valid starts on a frame
  a_r9_quiet_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (lane == '0));
  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
  a_r9_valid_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $rose(frame_clk));
endmodule

bind sser_serializer sser_serializer_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .bit_clk(bit_clk),
  .frame_clk(frame_clk), .out_valid(out_valid), .lane(lane)
);

// File: tb/sser_serializer_tb.sv
module sser_serializer_tb;
  localparam int CH  = 8;
  localparam int W   = 12;
  localparam int LAT = 12;
  localparam int NFR = 48;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [CH*W-1:0] in_data = '0;
  logic            fmt_twos = 1'b0;
  logic            pat_en = 1'b0;
  logic [CH-1:0]   lane;
  logic            bit_clk;
  logic            frame_clk;
  logic            out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [CH*W-1:0] acc [NFR];
  bit              cfg_pat [NFR+1];
  bit              cfg_fmt [NFR+1];
  logic [W-1:0]    got [CH];

  always #2.5 clk = ~clk;

  sser_serializer #(.CH(CH), .W(W), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .fmt_twos(fmt_twos), .pat_en(pat_en), .lane(lane),
    .bit_clk(bit_clk), .frame_clk(frame_clk), .out_valid(out_valid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] gen(input int k, input int c);
    if (k == 13) return (c % 2 == 1) ? 12'hFFF : 12'h000;
    return W'((k * 173 + c * 619 + 5) ^ (k << 4));
  endfunction

  function automatic bit bubble(input int k);
    return (k % 7 == 5);
  endfunction

  function automatic bit pat_sched(input int k, input int s);
    if (k == 28 && s >= 5) return 1'b1;
    if (k > 28 && k < 34) return 1'b1;
    if (k == 34 && s < 3) return 1'b1;
    if (k == 38 && s >= 2 && s < 7) return 1'b1;  // R8 pulse inside frame
    if (k == 41) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit fmt_sched(input int k);
    return (k >= 20 && k < 28) || k >= 40;
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", "lane in reset", int'(lane), 0);
    chk("R10", "out_valid in reset", int'(out_valid), 0);
    chk("R10", "in_ready in reset", int'(in_ready), 0);
    chk("R10", "bit_clk in reset", int'(bit_clk), 1);
    chk("R10", "frame_clk in reset", int'(frame_clk), 1);
    rst_n = 1'b1;

    for (int t = 0; t < NFR * W; t++) begin
      int s;
      int k;
      s = t % W;
      k = t / W;
      chk("R1", "bit_clk", int'(bit_clk), (s % 2 == 0) ? 1 : 0);
      chk("R2", "frame_clk", int'(frame_clk), (s < W / 2) ? 1 : 0);
      chk("R3", "in_ready", int'(in_ready), (s == W - 1) ? 1 : 0);
      chk("R9", "out_valid", int'(out_valid), (k >= LAT) ? 1 : 0);
      // R4: bit s of each word is on the lane in slot s
      for (int c = 0; c < CH; c++) got[c][s] = lane[c];
      if (s == W - 1) begin
        for (int c = 0; c < CH; c++) begin
          logic [W-1:0] exp;
          string tag;
          if (k < LAT) begin
            exp = '0;
            tag = "R9";
          end else if (cfg_pat[k]) begin
            exp = (k % 2 == 1) ? 12'h555 : 12'hAAA;
            tag = (k == 35 || k == 39) ? "R8" : "R7";
          end else begin
            exp = acc[k-LAT][c*W +: W];   // R3 bubbles stored as zero
            if (cfg_fmt[k]) exp[W-1] = ~exp[W-1];
            tag = (k == 35 || k == 39) ? "R8" : (cfg_fmt[k] ? "R6" : "R5");
          end
          chk(tag, $sformatf("frame %0d ch %0d word", k, c), int'(got[c]), int'(exp));
        end
      end
      // drive inputs for the next posedge
      in_valid = !bubble(k);
      for (int c = 0; c < CH; c++) in_data[c*W +: W] = gen(k, c);
      pat_en   = pat_sched(k, s);
      fmt_twos = fmt_sched(k);
      if (s == W - 1) begin
        acc[k]       = in_valid ? in_data : '0;
        cfg_pat[k+1] = pat_en;
        cfg_fmt[k+1] = fmt_twos;
      end
      @(negedge clk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule